// File: doc/BRIEF.md
# Processor-State Immediate Write Unit

This block executes the immediate form of the move-to-processor-state system instruction. It accepts the decoded `op1`, `op2` and `crm` fields with a valid strobe. It checks that the current exception level and security state permit the access, and that the selected field's feature is present. It then updates one field of a small register of processor-state flags.

Most fields are single bits that take `crm[0]`. The four interrupt-mask bits are handled differently: one encoding ORs `crm` into them and another clears the bits that `crm` names. A rejected instruction raises a one-cycle undefined pulse and leaves every flag as it was. A write of one to the all-interrupt mask from exception level 1 can instead be diverted into a trap request toward level 2 when the hypervisor trap control is set.

Flag register layout (`flags_o`): [3] debug mask, [2] SError mask, [1] IRQ mask, [0] FIQ mask, [4] stack-pointer select, [5] user-access override, [6] privileged-access-never, [7] constant-time, [8] tag-check override, [9] speculative-store-safe, [10] all-interrupt mask, [11] PMU-exception mask, [12] streaming mode, [13] array storage.

Top module: `pstate_imm_writer`

## Requirements
- R1: Synchronous reset sets `flags_o` to 14'h001F (all four interrupt masks and stack-pointer select set, others clear) and drives `undef_o`, `trap_o`, `trap_level_o` and `trap_class_o` to zero.
- R2: The minimum exception level is taken from `op1`: 000, 001, 010 and 111 need level 1; 011 needs level 0; 100 and 101 need level 2; 110 needs level 3. `op1`=111 also needs `secure_i`=1. A failed check gives an undefined pulse and no flag change.
- R3: With `op1`=101, the instruction is undefined when `feat_i[8]` (host virtualization) is 0.
- R4: The `{op1,op2}` selections for single-bit writes of `crm[0]` are: 000:011 to bit 5 (feature bit 0), 000:100 to bit 6 (feature bit 1), 000:101 to bit 4 (no feature), 011:010 to bit 7 (feature bit 4), 011:100 to bit 8 (feature bit 6), and 011:001 to bit 9 (feature bit 7).
- R5: With `{op1,op2}`=001:000, `crm[3:1]`=000 writes bit 10 (feature bit 2) and `crm[3:1]`=001 writes bit 11 (feature bit 3). Any other `crm` value is undefined.
- R6: With `{op1,op2}`=011:011, `crm[3:1]`=001 writes bit 12, 010 writes bit 13, and 011 writes `crm[0]` into both bits. All three need feature bit 5. Any other `crm` value is undefined.
- R7: `{op1,op2}` values 000:000, 000:001 and 000:010 belong to other instructions. They change no flag and raise neither undefined nor trap.
- R8: Every `{op1,op2}` combination not listed in R4 to R7, or in R10 and R11, is undefined and changes no flag.
- R9: A field whose feature bit in `feat_i` is 0 is undefined and changes no flag.
- R10: `{op1,op2}`=011:110 ORs `crm[3:0]` into `flags_o[3:0]`.
- R11: `{op1,op2}`=011:111 clears each bit of `flags_o[3:0]` whose matching `crm` bit is 1.
- R12: A permitted write of `crm[0]`=1 to the all-interrupt mask at level 1 with `hyp_trap_i`=1 leaves the flags unchanged and raises `trap_o` with `trap_level_o`=2 and `trap_class_o`=6'h18 instead of an undefined pulse.
- R13: Flags update on the clock edge that samples `valid_i`=1. The undefined and trap outputs are high only in the cycle after that edge. Without `valid_i`, no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| op1_i | input | 3 | First opcode field |
| op2_i | input | 3 | Second opcode field |
| crm_i | input | 4 | Immediate / sub-selector field |
| el_i | input | 2 | Current exception level |
| secure_i | input | 1 | Current state is secure |
| hyp_trap_i | input | 1 | Hypervisor traps all-interrupt mask sets from level 1 |
| feat_i | input | 9 | Implemented-feature enables (bit map in R4 to R6, R3) |
| flags_o | output | 14 | Processor-state flag register |
| undef_o | output | 1 | Undefined-instruction pulse |
| trap_o | output | 1 | Trap request pulse |
| trap_level_o | output | 2 | Trap target level |
| trap_class_o | output | 6 | Trap syndrome class |

## Verification
A wrong decode or a wrong gating decision is visible at the ports one cycle after the strobe. It shows up either as a flag bit that moved when it should not have, or as a missing or spurious undefined or trap pulse. A corrupted flag register persists, so the next comparison after the fault shows it regardless of which instruction follows. An exhaustive sweep of every field encoding at every level, in both security states, with all features on and all off and the trap control both ways, compares each cycle against an independent model. This sweep exposes any single wrong table entry within the cycle that uses it.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int FLAG_W = 14;
    localparam int FEAT_W = 9;
    localparam int OP_W   = 3;
    localparam int CRM_W  = 4;
    localparam int EL_W   = 2;
    localparam int CLS_W  = 6;

    localparam logic [FLAG_W-1:0] FLAG_RESET = 14'h001F;
    localparam logic [CLS_W-1:0]  TRAP_CLASS = 6'h18;
    localparam logic [EL_W-1:0]   TRAP_LEVEL = 2'd2;

    // feature enable positions
    localparam int FT_USER_OVR   = 0;
    localparam int FT_PRIV_NEVER = 1;
    localparam int FT_ALL_IRQ    = 2;
    localparam int FT_PMU_MASK   = 3;
    localparam int FT_CONST_TIME = 4;
    localparam int FT_STREAM     = 5;
    localparam int FT_TAG_OVR    = 6;
    localparam int FT_SPEC_SAFE  = 7;
    localparam int FT_HOST_VIRT  = 8;

    typedef struct packed {
        logic       array_store;
        logic       stream_mode;
        logic       pmu_mask;
        logic       all_irq_mask;
        logic       spec_safe;
        logic       tag_ovr;
        logic       const_time;
        logic       priv_never;
        logic       user_ovr;
        logic       sp_sel;
        logic [3:0] irq_masks;   // debug, serror, irq, fiq
    } flags_t;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_REDIR,
        FLD_USER_OVR,
        FLD_PRIV_NEVER,
        FLD_SP_SEL,
        FLD_CONST_TIME,
        FLD_TAG_OVR,
        FLD_SPEC_SAFE,
        FLD_MASK_SET,
        FLD_MASK_CLR,
        FLD_ALL_IRQ,
        FLD_PMU_MASK,
        FLD_STREAM,
        FLD_ARRAY,
        FLD_STREAM_ARRAY
    } field_e;

    function automatic logic [EL_W-1:0] min_level(input logic [OP_W-1:0] op1);
        case (op1)
            3'b011:         return 2'd0;
            3'b100, 3'b101: return 2'd2;
            3'b110:         return 2'd3;
            default:        return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/psw_field_dec.sv
module psw_field_dec
    import psw_pkg::*;
(
    input  logic [OP_W-1:0]   op1,
    input  logic [OP_W-1:0]   op2,
    input  logic [CRM_W-1:0]  crm,
    input  logic [FEAT_W-1:0] feat,
    output field_e            fld
);
    function automatic field_e gate(input logic en, input field_e f);
        return en ? f : FLD_NONE;
    endfunction

    always_comb begin
        fld = FLD_NONE;
        case ({op1, op2})
            6'o00, 6'o01, 6'o02: fld = FLD_REDIR;
            6'o03: fld = gate(feat[FT_USER_OVR], FLD_USER_OVR);
            6'o04: fld = gate(feat[FT_PRIV_NEVER], FLD_PRIV_NEVER);
            6'o05: fld = FLD_SP_SEL;
            6'o10: begin
                case (crm[3:1])
                    3'd0:    fld = gate(feat[FT_ALL_IRQ], FLD_ALL_IRQ);
                    3'd1:    fld = gate(feat[FT_PMU_MASK], FLD_PMU_MASK);
                    default: fld = FLD_NONE;
                endcase
            end
            6'o31: fld = gate(feat[FT_SPEC_SAFE], FLD_SPEC_SAFE);
            6'o32: fld = gate(feat[FT_CONST_TIME], FLD_CONST_TIME);
            6'o33: begin
                case (crm[3:1])
                    3'd1:    fld = gate(feat[FT_STREAM], FLD_STREAM);
                    3'd2:    fld = gate(feat[FT_STREAM], FLD_ARRAY);
                    3'd3:    fld = gate(feat[FT_STREAM], FLD_STREAM_ARRAY);
                    default: fld = FLD_NONE;
                endcase
            end
            6'o34: fld = gate(feat[FT_TAG_OVR], FLD_TAG_OVR);
            6'o36: fld = FLD_MASK_SET;
            6'o37: fld = FLD_MASK_CLR;
            default: fld = FLD_NONE;
        endcase
    end
endmodule

// File: rtl/psw_access_chk.sv
module psw_access_chk
    import psw_pkg::*;
(
    input  logic [OP_W-1:0]   op1,
    input  logic [EL_W-1:0]   el,
    input  logic              secure,
    input  logic [FEAT_W-1:0] feat,
    output logic              allow
);
    logic level_ok, sec_ok, feat_ok;

    always_comb begin
        level_ok = (el >= min_level(op1));
        sec_ok   = (op1 != 3'b111) || secure;
        feat_ok  = (op1 != 3'b101) || feat[FT_HOST_VIRT];
        allow    = level_ok && sec_ok && feat_ok;
    end
endmodule

// File: rtl/pstate_imm_writer.sv
module pstate_imm_writer
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op1_i,
    input  logic [2:0]        op2_i,
    input  logic [3:0]        crm_i,
    input  logic [1:0]        el_i,
    input  logic              secure_i,
    input  logic              hyp_trap_i,
    input  logic [8:0]        feat_i,
    output logic [13:0]       flags_o,
    output logic              undef_o,
    output logic              trap_o,
    output logic [1:0]        trap_level_o,
    output logic [5:0]        trap_class_o
);
    field_e fld;
    logic   allow;
    flags_t cur, nxt;
    logic   nxt_undef, nxt_trap;

    psw_field_dec u_dec (
        .op1 (op1_i), .op2 (op2_i), .crm (crm_i), .feat (feat_i), .fld (fld)
    );

    psw_access_chk u_acc (
        .op1 (op1_i), .el (el_i), .secure (secure_i), .feat (feat_i), .allow (allow)
    );

    always_comb begin
        nxt       = cur;
        nxt_undef = 1'b0;
        nxt_trap  = 1'b0;
        if (fld != FLD_REDIR) begin
            if (!allow || fld == FLD_NONE) begin
                nxt_undef = 1'b1;
            end else begin
                case (fld)
                    FLD_USER_OVR:   nxt.user_ovr   = crm_i[0];
                    FLD_PRIV_NEVER: nxt.priv_never = crm_i[0];
                    FLD_SP_SEL:     nxt.sp_sel     = crm_i[0];
                    FLD_CONST_TIME: nxt.const_time = crm_i[0];
                    FLD_TAG_OVR:    nxt.tag_ovr    = crm_i[0];
                    FLD_SPEC_SAFE:  nxt.spec_safe  = crm_i[0];
                    FLD_PMU_MASK:   nxt.pmu_mask   = crm_i[0];
                    FLD_STREAM:     nxt.stream_mode = crm_i[0];
                    FLD_ARRAY:      nxt.array_store = crm_i[0];
                    FLD_STREAM_ARRAY: begin
                        nxt.stream_mode = crm_i[0];
                        nxt.array_store = crm_i[0];
                    end
                    FLD_MASK_SET: nxt.irq_masks = cur.irq_masks | crm_i;
                    FLD_MASK_CLR: nxt.irq_masks = cur.irq_masks & ~crm_i;
                    FLD_ALL_IRQ: begin
                        if (el_i == 2'd1 && hyp_trap_i && crm_i[0])
                            nxt_trap = 1'b1;
                        else
                            nxt.all_irq_mask = crm_i[0];
                    end
                    default: nxt = cur;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur          <= flags_t'(FLAG_RESET);
            undef_o      <= 1'b0;
            trap_o       <= 1'b0;
            trap_level_o <= '0;
            trap_class_o <= '0;
        end else begin
            undef_o      <= valid_i && nxt_undef;
            trap_o       <= valid_i && nxt_trap;
            trap_level_o <= (valid_i && nxt_trap) ? TRAP_LEVEL : '0;
            trap_class_o <= (valid_i && nxt_trap) ? TRAP_CLASS : '0;
            if (valid_i) cur <= nxt;
        end
    end

    assign flags_o = cur;

    // R13: without a strobe, nothing moves and no pulse follows
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!undef_o && !trap_o && $stable(flags_o)));

    // R2 / R8 / R9: a rejected instruction leaves the flags alone
    a_r2_undef_no_change: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> $stable(flags_o));

    // R12: a trap leaves flags alone, targets level 2 with class 0x18
    a_r12_trap_effect: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($stable(flags_o) && !undef_o &&
                    trap_level_o == 2'd2 && trap_class_o == 6'h18));

    // R10: the set form never clears a mask bit
    a_r10_set_monotone: assert property (@(posedge clk) disable iff (rst)
        (valid_i && allow && fld == FLD_MASK_SET) |=>
        ((flags_o[3:0] & $past(flags_o[3:0])) == $past(flags_o[3:0])));

    // R11: the clear form never sets a mask bit
    a_r11_clr_monotone: assert property (@(posedge clk) disable iff (rst)
        (valid_i && allow && fld == FLD_MASK_CLR) |=>
        ((flags_o[3:0] | $past(flags_o[3:0])) == $past(flags_o[3:0])));

    // R7: redirected encodings raise nothing
    a_r7_redirect_silent: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fld == FLD_REDIR) |=> (!undef_o && !trap_o && $stable(flags_o)));

endmodule

// File: tb/pstate_imm_writer_tb_top.sv
`timescale 1ns/1ps
module pstate_imm_writer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i = 1'b0;
    logic [2:0]  op1_i = '0, op2_i = '0;
    logic [3:0]  crm_i = '0;
    logic [1:0]  el_i = '0;
    logic        secure_i = 1'b0, hyp_trap_i = 1'b0;
    logic [8:0]  feat_i = '0;
    logic [13:0] flags_o;
    logic        undef_o, trap_o;
    logic [1:0]  trap_level_o;
    logic [5:0]  trap_class_o;

    int errs = 0;
    int checks = 0;
    logic [13:0] mf;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pstate_imm_writer dut_i (
        .clk (clk), .rst (rst), .valid_i (valid_i),
        .op1_i (op1_i), .op2_i (op2_i), .crm_i (crm_i),
        .el_i (el_i), .secure_i (secure_i), .hyp_trap_i (hyp_trap_i),
        .feat_i (feat_i), .flags_o (flags_o), .undef_o (undef_o),
        .trap_o (trap_o), .trap_level_o (trap_level_o), .trap_class_o (trap_class_o)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h (op1=%0d op2=%0d crm=%0d el=%0d sec=%0d feat=%h hyp=%0d)",
                     req, act, exp, op1_i, op2_i, crm_i, el_i, secure_i, feat_i, hyp_trap_i);
        end
    endtask

    // behavioural reference: returns tag and expected values
    task automatic model(input int o1, input int o2, input int c, input int el,
                         input bit sec, input logic [8:0] fe, input bit hyp,
                         output string tag, output bit x_undef, output bit x_trap,
                         output logic [13:0] x_flags);
        int code;
        int need;
        int bitpos;
        bit feat_ok;
        bit known;
        code = o1 * 8 + o2;
        x_flags = mf; x_undef = 0; x_trap = 0; tag = "R8";
        bitpos = -1; feat_ok = 1; known = 1;
        if (code <= 2) begin tag = "R7"; return; end
        need = (o1 == 3) ? 0 : (o1 == 4 || o1 == 5) ? 2 : (o1 == 6) ? 3 : 1;
        if (el < need || (o1 == 7 && !sec)) begin tag = "R2"; x_undef = 1; return; end
        if (o1 == 5 && !fe[8]) begin tag = "R3"; x_undef = 1; return; end
        if (code == 3)       begin bitpos = 5;  feat_ok = fe[0]; tag = "R4"; end
        else if (code == 4)  begin bitpos = 6;  feat_ok = fe[1]; tag = "R4"; end
        else if (code == 5)  begin bitpos = 4;  tag = "R4"; end
        else if (code == 26) begin bitpos = 7;  feat_ok = fe[4]; tag = "R4"; end
        else if (code == 28) begin bitpos = 8;  feat_ok = fe[6]; tag = "R4"; end
        else if (code == 25) begin bitpos = 9;  feat_ok = fe[7]; tag = "R4"; end
        else if (code == 8) begin
            tag = "R5";
            if (c / 2 == 0)      begin bitpos = 10; feat_ok = fe[2]; end
            else if (c / 2 == 1) begin bitpos = 11; feat_ok = fe[3]; end
            else known = 0;
        end else if (code == 27) begin
            tag = "R6"; feat_ok = fe[5];
            if (c / 2 == 1)      bitpos = 12;
            else if (c / 2 == 2) bitpos = 13;
            else if (c / 2 == 3) bitpos = 14;   // both
            else known = 0;
        end else if (code == 30) begin
            tag = "R10";
            x_flags[3:0] = mf[3:0] | c[3:0];
            return;
        end else if (code == 31) begin
            tag = "R11";
            x_flags[3:0] = mf[3:0] & ~c[3:0];
            return;
        end else known = 0;
        if (!known) begin x_undef = 1; return; end
        if (!feat_ok) begin tag = "R9"; x_undef = 1; return; end
        if (bitpos == 10 && el == 1 && hyp && c[0]) begin
            tag = "R12"; x_trap = 1; return;
        end
        if (bitpos == 14) begin
            x_flags[12] = c[0]; x_flags[13] = c[0];
        end else x_flags[bitpos] = c[0];
    endtask

    task automatic run_op(input int o1, input int o2, input int c, input int el,
                          input bit sec, input logic [8:0] fe, input bit hyp);
        string tag;
        bit xu, xt;
        logic [13:0] xf;
        op1_i = o1[2:0]; op2_i = o2[2:0]; crm_i = c[3:0]; el_i = el[1:0];
        secure_i = sec; feat_i = fe; hyp_trap_i = hyp; valid_i = 1'b1;
        model(o1, o2, c, el, sec, fe, hyp, tag, xu, xt, xf);
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, {flags_o, undef_o, trap_o, trap_level_o, trap_class_o},
              {xf, xu, xt, xt ? 2'd2 : 2'd0, xt ? 6'h18 : 6'h00});
        mf = xf;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mf = 14'h001F;
        // R1: reset state
        check("R1", {flags_o, undef_o, trap_o, trap_level_o, trap_class_o},
              {14'h001F, 1'b0, 1'b0, 2'd0, 6'd0});
        // R10 / R11 directed: clear masks then set two
        run_op(3, 7, 15, 1, 0, 9'h1FF, 0);
        run_op(3, 6, 5, 1, 0, 9'h1FF, 0);
        // R12 directed: trap then allowed write at level 2
        run_op(1, 0, 1, 1, 0, 9'h1FF, 1);
        run_op(1, 0, 1, 2, 0, 9'h1FF, 1);
        // R13: idle cycles change nothing
        repeat (2) @(negedge clk);
        check("R13", {flags_o, undef_o, trap_o, trap_level_o, trap_class_o},
              {mf, 1'b0, 1'b0, 2'd0, 6'd0});
        // exhaustive sweep against the reference
        for (int fsel = 0; fsel < 2; fsel++)
            for (int hyp = 0; hyp < 2; hyp++)
                for (int sec = 0; sec < 2; sec++)
                    for (int el = 0; el < 4; el++)
                        for (int o1 = 0; o1 < 8; o1++)
                            for (int o2 = 0; o2 < 8; o2++)
                                for (int c = 0; c < 16; c++)
                                    run_op(o1, o2, c, el, sec[0],
                                           fsel == 0 ? 9'h1FF : 9'h000, hyp[0]);
        @(negedge clk);
        check("R13", {flags_o, undef_o, trap_o}, {mf, 1'b0, 1'b0});
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule